// File: doc/BRIEF.md
# Pulse-swallowing decimal stopwatch counter

This block keeps a three-digit decimal stopwatch count with millisecond resolution, driven from a binary 1,024 Hz tick. The ticks are not all counted: at 24 fixed points in each count cycle, the tick after the count lands on that point is dropped. Because of this, exactly 1,000 counts occur over every 1,024 ticks, and the rate is exactly decimal over one second.

The digits are, from lowest to highest, thousandths, hundredths and tenths of a second. Each digit steps on the carry of the digit below it. When the count rolls over from 999 to 000, the block raises a one-cycle pulse, once per second.

The tick strobe, run enable and reset are plain control pins. No data handshake exists: a tick is counted in the cycle it is present, there is no back-pressure, and a tick that arrives while the block is stopped is lost.

Top module: `sw_decimal_counter`

## Requirements
- R1: Each of the three digit outputs is a BCD value in the range 0 to 9. `ms_digit` is the thousandths digit, `cs_digit` the hundredths digit and `ds_digit` the tenths digit. The count value is ds*100 + cs*10 + ms.
- R2: A counted tick increments the count by one at the next clock edge. A digit that steps from 9 goes to 0 and steps the digit above it in the same edge.
- R3: The swallow points are count values 39, 79, 139, 179, 219, 259, 299, 319, 359, 399, 439, 479, 539, 579, 619, 659, 699, 719, 759, 799, 839, 879, 939 and 979. When a counted tick makes the count equal one of these values, the next accepted tick leaves the count unchanged. The tick after that counts normally. Only one tick is dropped for each swallow point.
- R4: Starting from 000, 1,024 accepted ticks produce exactly 1,000 count increments and bring the count back to 000.
- R5: The step from 999 to 000 raises `sec_pulse` for exactly one clock. That clock is the one in which the digits first show 000. The pulse is low at all other times.
- R6: While `run_en` is low, ticks are ignored. The digits hold, and a pending swallow stays pending until the next tick that arrives with `run_en` high.
- R7: A high `rst_sync` at a clock edge clears all digits, the pending swallow and `sec_pulse`. Reset takes priority over a tick in the same cycle.
- R8: With no tick present, the digits do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_sync | input | 1 | Synchronous reset, active high |
| tick_1k | input | 1 | One-cycle strobe at 1,024 Hz |
| run_en | input | 1 | High lets ticks reach the counter |
| ms_digit | output | 4 | Thousandths digit, BCD |
| cs_digit | output | 4 | Hundredths digit, BCD |
| ds_digit | output | 4 | Tenths digit, BCD |
| sec_pulse | output | 1 | One-cycle pulse on wrap to 000 |

## Verification
Two functions can meet in one tick: a pending swallow and a stop request. This is provoked by driving the count onto 039 and then sending ticks with `run_en` low. The judgement is that the count holds through those ticks, that the first tick after restart is still dropped, and that the tick after that steps the count to 040. The second case is reset and a tick in the same cycle. There the cleared state must win over the increment. In both cases, every tick is scored against a reference model that knows the swallow points.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int DIGIT_W   = 4;
  localparam int N_DIGITS  = 3;
  localparam int DIGIT_MAX = 9;
  localparam int WRAP_VAL  = 1000;

  typedef logic [DIGIT_W-1:0] bcd_t;

  // Count values after which the following tick is dropped (24 per wrap).
  function automatic logic swallow_point(input bcd_t hi, input bcd_t mid, input bcd_t lo);
    int v;
    v = int'(hi) * 100 + int'(mid) * 10 + int'(lo);
    case (v)
      39, 79, 139, 179, 219, 259, 299, 319, 359, 399, 439, 479,
      539, 579, 619, 659, 699, 719, 759, 799, 839, 879, 939, 979:
        swallow_point = 1'b1;
      default:
        swallow_point = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/sw_bcd_digit.sv
module sw_bcd_digit #(
  parameter int W   = 4,
  parameter int MAX = 9
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] q,
  output logic [W-1:0] q_next,
  output logic         carry
);
  localparam logic [W-1:0] TOP = W'(MAX);

  always_comb begin
    q_next = q;
    if (step) q_next = (q == TOP) ? '0 : q + W'(1);
  end

  assign carry = step && (q == TOP);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= q_next;
  end
endmodule

// File: rtl/sw_pulse_gate.sv
module sw_pulse_gate (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic run,
  input  logic land_hit,
  output logic adv,
  output logic pending
);
  logic accept;
  assign accept = tick && run;
  assign adv    = accept && !pending;

  always_ff @(posedge clk) begin
    if (rst)          pending <= 1'b0;
    else if (accept)  pending <= pending ? 1'b0 : land_hit;
  end
endmodule

// File: rtl/sw_decimal_counter.sv
module sw_decimal_counter
  import sw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_sync,
  input  logic       tick_1k,
  input  logic       run_en,
  output logic [3:0] ms_digit,
  output logic [3:0] cs_digit,
  output logic [3:0] ds_digit,
  output logic       sec_pulse
);
  logic [N_DIGITS:0]              step_chain;
  logic [N_DIGITS-1:0][DIGIT_W-1:0] dig_q;
  logic [N_DIGITS-1:0][DIGIT_W-1:0] dig_nx;
  logic [N_DIGITS-1:0]            dig_cy;
  logic adv, pending_q, land_hit;

  sw_pulse_gate gate_i (
    .clk(clk), .rst(rst_sync), .tick(tick_1k), .run(run_en),
    .land_hit(land_hit), .adv(adv), .pending(pending_q)
  );

  assign step_chain[0] = adv;

  for (genvar g = 0; g < N_DIGITS; g++) begin : g_digit
    sw_bcd_digit #(.W(DIGIT_W), .MAX(DIGIT_MAX)) dig_i (
      .clk(clk), .rst(rst_sync), .step(step_chain[g]),
      .q(dig_q[g]), .q_next(dig_nx[g]), .carry(dig_cy[g])
    );
    assign step_chain[g+1] = dig_cy[g];
  end

  assign land_hit = swallow_point(dig_nx[2], dig_nx[1], dig_nx[0]);

  always_ff @(posedge clk) begin
    if (rst_sync) sec_pulse <= 1'b0;
    else          sec_pulse <= step_chain[N_DIGITS];
  end

  assign ms_digit = dig_q[0];
  assign cs_digit = dig_q[1];
  assign ds_digit = dig_q[2];
endmodule

// File: rtl/sw_decimal_counter_chk.sv
module sw_decimal_counter_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic       run,
  input logic [3:0] ms,
  input logic [3:0] cs,
  input logic [3:0] ds,
  input logic       sec,
  input logic       pending
);
  p_bcd_range_r1: assert property (@(posedge clk) disable iff (rst)
    (ms <= 4'd9) && (cs <= 4'd9) && (ds <= 4'd9));

  p_ms_step_r2: assert property (@(posedge clk) disable iff (rst)
    (tick && run && !pending) |=> (ms == (($past(ms) == 4'd9) ? 4'd0 : $past(ms) + 4'd1)));

  p_swallow_once_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && run && pending) |=> ($stable(ms) && $stable(cs) && $stable(ds) && !pending));

  p_sec_on_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(sec) |-> (ms == 4'd0 && cs == 4'd0 && ds == 4'd0));

  p_sec_single_r5: assert property (@(posedge clk) disable iff (rst)
    sec |=> !sec);

  p_freeze_r6: assert property (@(posedge clk) disable iff (rst)
    !run |=> ($stable(ms) && $stable(cs) && $stable(ds) && $stable(pending)));

  p_reset_clear_r7: assert property (@(posedge clk)
    rst |=> (ms == 4'd0 && cs == 4'd0 && ds == 4'd0 && !sec && !pending));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(ms) && $stable(cs) && $stable(ds)));
endmodule

bind sw_decimal_counter sw_decimal_counter_chk chk_i (
  .clk(clk), .rst(rst_sync), .tick(tick_1k), .run(run_en),
  .ms(ms_digit), .cs(cs_digit), .ds(ds_digit), .sec(sec_pulse),
  .pending(pending_q)
);

// File: tb/sw_decimal_counter_tb_top.sv
module sw_decimal_counter_tb_top;
  logic clk = 1'b0;
  logic rst_sync = 1'b1;
  logic tick_1k = 1'b0;
  logic run_en = 1'b1;
  logic [3:0] ms_digit, cs_digit, ds_digit;
  logic sec_pulse;

  int checks = 0;
  int failures = 0;
  int incr_seen = 0;
  int sec_seen = 0;
  int prev_val = 0;

  int  m_val = 0;
  bit  m_skip = 1'b0;
  typedef struct { int val; bit sec; } exp_t;
  exp_t sb_q[$];

  int skip_tab[24] = '{39, 79, 139, 179, 219, 259, 299, 319, 359, 399, 439, 479,
                       539, 579, 619, 659, 699, 719, 759, 799, 839, 879, 939, 979};

  always #2 clk = ~clk;

  sw_decimal_counter dut_i (
    .clk(clk), .rst_sync(rst_sync), .tick_1k(tick_1k), .run_en(run_en),
    .ms_digit(ms_digit), .cs_digit(cs_digit), .ds_digit(ds_digit),
    .sec_pulse(sec_pulse)
  );

  function automatic int dut_val();
    return int'(ds_digit) * 100 + int'(cs_digit) * 10 + int'(ms_digit);
  endfunction

  function automatic bit in_tab(int v);
    foreach (skip_tab[k]) if (skip_tab[k] == v) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: model the tick, queue the expectation, pulse the strobe.
  task automatic drive_tick(int gap);
    exp_t e;
    e.sec = 1'b0;
    if (run_en) begin
      if (m_skip) m_skip = 1'b0;
      else begin
        m_val  = (m_val + 1) % 1000;
        e.sec  = (m_val == 0);
        m_skip = in_tab(m_val);
      end
    end
    e.val = m_val;
    sb_q.push_back(e);
    @(negedge clk) tick_1k = 1'b1;
    @(negedge clk) tick_1k = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk) rst_sync = 1'b1;
    @(negedge clk) rst_sync = 1'b0;
    m_val = 0; m_skip = 1'b0;
    prev_val = 0;
  endtask

  // Monitor: score every tick after the edge that consumed it.
  initial begin
    forever begin
      @(posedge clk);
      if (tick_1k && !rst_sync) begin
        exp_t e;
        @(negedge clk);
        if (sb_q.size() == 0) check(1'b0, "R2 scoreboard empty", 0, 1);
        else begin
          e = sb_q.pop_front();
          check(ms_digit <= 9 && cs_digit <= 9 && ds_digit <= 9, "R1 bcd range",
                dut_val(), e.val);
          check(dut_val() == e.val, "R2/R3 count", dut_val(), e.val);
          check(sec_pulse == e.sec, "R5 sec_pulse", sec_pulse, e.sec);
          if (dut_val() != prev_val) incr_seen++;
          if (sec_pulse) sec_seen++;
          prev_val = dut_val();
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_sync = 1'b0;
    m_val = 0; m_skip = 1'b0;
    @(negedge clk);
    check(dut_val() == 0 && !sec_pulse, "R7 reset state", dut_val(), 0);

    // R4 / R5: one full second of ticks
    incr_seen = 0; sec_seen = 0;
    for (int i = 0; i < 1024; i++) drive_tick(0);
    repeat (2) @(negedge clk);
    check(incr_seen == 1000, "R4 increments per 1024 ticks", incr_seen, 1000);
    check(dut_val() == 0, "R4 back at 000", dut_val(), 0);
    check(sec_seen == 1, "R5 one sec pulse", sec_seen, 1);
    check(sec_pulse == 1'b0, "R5 pulse one clock", sec_pulse, 0);

    // R3 + R6: pending swallow meets stop
    do_reset();
    for (int i = 0; i < 39; i++) drive_tick(1);
    repeat (2) @(negedge clk);
    check(dut_val() == 39, "R3 landed on 039", dut_val(), 39);
    run_en = 1'b0;
    for (int i = 0; i < 3; i++) drive_tick(1);
    repeat (2) @(negedge clk);
    check(dut_val() == 39, "R6 frozen while stopped", dut_val(), 39);
    run_en = 1'b1;
    drive_tick(1);
    repeat (2) @(negedge clk);
    check(dut_val() == 39, "R3 R6 swallow kept pending", dut_val(), 39);
    drive_tick(1);
    repeat (2) @(negedge clk);
    check(dut_val() == 40, "R3 resumes after swallow", dut_val(), 40);

    // R8: idle hold
    repeat (10) @(negedge clk);
    check(dut_val() == 40, "R8 idle hold", dut_val(), 40);

    // R7: reset wins over a tick in the same cycle
    @(negedge clk); rst_sync = 1'b1; tick_1k = 1'b1;
    @(negedge clk); rst_sync = 1'b0; tick_1k = 1'b0;
    m_val = 0; m_skip = 1'b0; prev_val = 0;
    check(dut_val() == 0 && !sec_pulse, "R7 reset over tick", dut_val(), 0);

    // Mixed gaps and run toggles over more than a second
    for (int i = 0; i < 1500; i++) begin
      run_en = ((i % 37) != 5);
      drive_tick(i % 3);
    end
    run_en = 1'b1;
    repeat (3) @(negedge clk);
    check(sb_q.size() == 0, "R2 scoreboard drained", sb_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule